// File: doc/BRIEF.md
# LNB Supply Protection Fault Sequencer

This block turns digital protection indications from a satellite antenna supply into power-stage control and status. Four kinds of event come in: overtemperature, backward current into the output, a current clamp in static current-limit mode, and loss of supply (power not OK). An interface reset request also comes in. From these the block drives the enable of the boost and linear stage, keeps three status flags, and drives an active-low fault line for the host processor.

An overtemperature event turns the stage off only while it lasts. A counter tracks the shutdowns, and the fourth one while enabled locks the stage off until software gives the enable a fresh rising edge or supply is lost. A sustained backward current starts a retry pattern: the stage stays enabled through a sensing window of RUN_MS milliseconds, and is then held off for HOLD_MS milliseconds. All windows are counted in ticks of a known system clock, with `TICKS_PER_MS` as a parameter. The overload flag tracks the clamp during a soft-start interval, and that interval restarts on each rising edge of the enable.

Top module: `lnb_prot_seq`

## Requirements
- R1: While reset is applied, or one cycle after `pwr_ok_i` is low, `stage_en_o`, `otf_o`, `bcf_o` and `olf_o` are 0 and `fault_n_o` is 0.
- R2: One cycle after `hot_i` is high, `otf_o` is 1 and `stage_en_o` is 0. When `hot_i` falls and the block is not latched, `otf_o` returns to 0 and the stage is enabled again one cycle later.
- R3: The rising edges of `hot_i` that occur while `en_i` and `pwr_ok_i` are high are counted. On the fourth such edge the block latches. From then on `otf_o` stays 1, `stage_en_o` stays 0 and `fault_n_o` stays 0 after `hot_i` clears, and this holds even while `en_i` is low.
- R4: The thermal latch and the shutdown count are cleared by a rising edge of `en_i` or by `pwr_ok_i` low. After a clear, four new shutdowns are needed to latch again.
- R5: If `back_i` is high for RUN_TICKS consecutive armed cycles, `bcf_o` becomes 1 and `stage_en_o` becomes 0 for exactly HOLD_TICKS cycles. RUN_TICKS is RUN_MS×TICKS_PER_MS and HOLD_TICKS is HOLD_MS×TICKS_PER_MS.
- R6: If `back_i` stays high, the block keeps alternating between RUN_TICKS enabled cycles and HOLD_TICKS held-off cycles. Once `back_i` is low, the stage stays enabled after the current hold ends.
- R7: A drop of `back_i` before RUN_TICKS consecutive cycles resets the duration count, so two high bursts of RUN_TICKS-1 cycles separated by a low cycle never set `bcf_o`.
- R8: One cycle after `clamp_i` is high with `static_lim_i` high and the block armed, `olf_o` is 1. The flag stays set until it is cleared. `clamp_i` has no effect while `static_lim_i` is low, and `olf_o` is 0 while the block is not armed.
- R9: `olf_o` clears at the edge that ends the soft-start interval. The end of soft start wins over a clamp in the same cycle.
- R10: A rising edge of armed enable (`en_i` and `pwr_ok_i`) restarts soft start, which ends SOFTSTART_TICKS edges after that rising edge.
- R11: `fault_n_o` is the registered inverse of: `otf_o`, `olf_o`, power not OK, or `if_rst_i`. An interface reset alone pulls it low without disabling the stage.
- R12: `stage_en_o` is 1 one cycle after `en_i` and `pwr_ok_i` are both high, provided neither `otf_o` nor `bcf_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply above lockout threshold |
| if_rst_i | input | 1 | Interface reset condition |
| en_i | input | 1 | Output enable from control register |
| static_lim_i | input | 1 | Static current-limit mode select |
| hot_i | input | 1 | Overtemperature indication |
| back_i | input | 1 | Backward current indication |
| clamp_i | input | 1 | Current clamp reached |
| stage_en_o | output | 1 | Power-stage enable |
| otf_o | output | 1 | Overtemperature flag |
| bcf_o | output | 1 | Backward-current flag |
| olf_o | output | 1 | Overload flag |
| fault_n_o | output | 1 | Active-low fault line |

## Verification
The overload flag can be set by a clamp and cleared by the end of soft start in the same cycle. The bench provokes this by raising `clamp_i` in exactly the cycle before the final soft-start edge, with static mode on. It counts that edge from the enable rising edge and judges by requiring `olf_o` low and `fault_n_o` high right after it. A second collision is an enable rising edge while the thermal latch is set: the bench checks that the latch clears and the stage turns on in that same cycle.

// File: rtl/lnb_prot_pkg.sv
package lnb_prot_pkg;
  typedef enum logic {
    BC_RUN  = 1'b0,
    BC_HOLD = 1'b1
  } bc_state_e;
endpackage

// File: rtl/prot_softstart.sv
module prot_softstart #(
  parameter int unsigned SS_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic static_i,
  input  logic clamp_i,
  output logic olf_o
);
  localparam int unsigned CW = $clog2(SS_TICKS + 1);

  logic          arm_q, active_q, olf_q;
  logic [CW-1:0] cnt_q;
  logic          rise, finish;

  assign rise   = arm_i & ~arm_q;
  assign finish = active_q & (cnt_q == CW'(SS_TICKS - 1));
  assign olf_o  = olf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q    <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      olf_q    <= 1'b0;
    end else begin
      arm_q <= arm_i;
      if (!arm_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        olf_q    <= 1'b0;
      end else begin
        if (rise) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
        end else if (finish) begin
          active_q <= 1'b0;
        end else if (active_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
        // end of soft start wins over a same-cycle clamp
        if (finish)                  olf_q <= 1'b0;
        else if (static_i & clamp_i) olf_q <= 1'b1;
      end
    end
  end

  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> !olf_o); // R9
  AST_STATIC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!olf_o && !static_i) |=> !olf_o); // R8
  AST_SS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> active_q); // R10
endmodule

// File: rtl/prot_thermal.sv
module prot_thermal #(
  parameter int unsigned TRIP_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic arm_i,
  input  logic clr_i,
  input  logic hot_i,
  output logic otf_o
);
  localparam int unsigned CW = $clog2(TRIP_LIMIT + 1);

  logic [CW-1:0] trips_q;
  logic          hot_q, latch_q, latch_d, otf_q, evt;

  assign evt   = arm_i & hot_i & ~hot_q & ~latch_q;
  assign otf_o = otf_q;

  always_comb begin
    if (clr_i) latch_d = 1'b0;
    else       latch_d = latch_q | (evt && (trips_q == CW'(TRIP_LIMIT - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q   <= 1'b0;
      trips_q <= '0;
      latch_q <= 1'b0;
      otf_q   <= 1'b0;
    end else begin
      hot_q   <= hot_i;
      latch_q <= latch_d;
      otf_q   <= pwr_ok_i & (hot_i | latch_d);
      if (clr_i)    trips_q <= '0;
      else if (evt) trips_q <= trips_q + 1'b1;
    end
  end

  AST_OTF_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && hot_i) |=> otf_o); // R2
  AST_LATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !clr_i) |=> (latch_q && otf_o)); // R3
  AST_LATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latch_q); // R4
  AST_TRIP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trips_q <= CW'(TRIP_LIMIT)); // R3
endmodule

// File: rtl/prot_backcur.sv
module prot_backcur
  import lnb_prot_pkg::*;
#(
  parameter int unsigned RUN_TICKS  = 8,
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic back_i,
  output logic hold_o
);
  localparam int unsigned RW = $clog2(RUN_TICKS + 1);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);

  bc_state_e     state_q;
  logic [RW-1:0] run_cnt_q;
  logic [HW-1:0] hold_cnt_q;

  assign hold_o = (state_q == BC_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= BC_RUN;
      run_cnt_q  <= '0;
      hold_cnt_q <= '0;
    end else if (!arm_i) begin
      state_q    <= BC_RUN;
      run_cnt_q  <= '0;
      hold_cnt_q <= '0;
    end else if (state_q == BC_RUN) begin
      if (!back_i) begin
        run_cnt_q <= '0;
      end else if (run_cnt_q == RW'(RUN_TICKS - 1)) begin
        state_q    <= BC_HOLD;
        run_cnt_q  <= '0;
        hold_cnt_q <= '0;
      end else begin
        run_cnt_q <= run_cnt_q + 1'b1;
      end
    end else begin
      if (hold_cnt_q == HW'(HOLD_TICKS - 1)) state_q    <= BC_RUN;
      else                                   hold_cnt_q <= hold_cnt_q + 1'b1;
    end
  end

  AST_RUN_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BC_RUN && !back_i) |=> !hold_o); // R7
  AST_HOLD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt_q < HW'(HOLD_TICKS)); // R5
  AST_DISARM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !hold_o); // R6
endmodule

// File: rtl/lnb_prot_seq.sv
module lnb_prot_seq #(
  parameter int unsigned TICKS_PER_MS    = 125000,
  parameter int unsigned RUN_MS          = 2,
  parameter int unsigned HOLD_MS         = 50,
  parameter int unsigned SOFTSTART_TICKS = 1250000,
  parameter int unsigned THERM_TRIPS     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic if_rst_i,
  input  logic en_i,
  input  logic static_lim_i,
  input  logic hot_i,
  input  logic back_i,
  input  logic clamp_i,
  output logic stage_en_o,
  output logic otf_o,
  output logic bcf_o,
  output logic olf_o,
  output logic fault_n_o
);
  localparam int unsigned RUN_TICKS  = RUN_MS * TICKS_PER_MS;
  localparam int unsigned HOLD_TICKS = HOLD_MS * TICKS_PER_MS;

  logic pwr_q, ifr_q, en_q, run_q;
  logic arm, therm_clr;

  assign arm       = en_i & pwr_ok_i;
  assign therm_clr = ~pwr_ok_i | (en_i & ~en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= 1'b0;
      ifr_q <= 1'b0;
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      pwr_q <= pwr_ok_i;
      ifr_q <= if_rst_i;
      en_q  <= en_i;
      run_q <= arm;
    end
  end

  prot_thermal #(.TRIP_LIMIT(THERM_TRIPS)) i_thermal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .arm_i    (arm),
    .clr_i    (therm_clr),
    .hot_i    (hot_i),
    .otf_o    (otf_o)
  );

  prot_backcur #(.RUN_TICKS(RUN_TICKS), .HOLD_TICKS(HOLD_TICKS)) i_backcur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .back_i (back_i),
    .hold_o (bcf_o)
  );

  prot_softstart #(.SS_TICKS(SOFTSTART_TICKS)) i_softstart (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .static_i (static_lim_i),
    .clamp_i  (clamp_i),
    .olf_o    (olf_o)
  );

  assign stage_en_o = run_q & ~otf_o & ~bcf_o;
  assign fault_n_o  = ~(otf_o | olf_o | ~pwr_q | ifr_q);

  AST_PWR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (!fault_n_o && !stage_en_o && !otf_o)); // R1
  AST_IFRST_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_i |=> !fault_n_o); // R11
  AST_EN_GATES_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stage_en_o); // R12
endmodule

// File: tb/test_lnb_prot_seq.sv
`timescale 1ns/1ps
module test_lnb_prot_seq;
  localparam int unsigned TPM  = 4;
  localparam int unsigned SS   = 12;
  localparam int unsigned RUN  = 2 * TPM;
  localparam int unsigned HOLD = 50 * TPM;
  localparam logic [4:0] ALL = 5'b11111;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_ok_i = 1'b0, if_rst_i = 1'b0, en_i = 1'b0, static_lim_i = 1'b0;
  logic hot_i = 1'b0, back_i = 1'b0, clamp_i = 1'b0;
  logic stage_en_o, otf_o, bcf_o, olf_o, fault_n_o;

  always #4 clk_i = ~clk_i;

  lnb_prot_seq #(
    .TICKS_PER_MS(TPM), .RUN_MS(2), .HOLD_MS(50),
    .SOFTSTART_TICKS(SS), .THERM_TRIPS(4)
  ) i_lnb_prot_seq (
    .clk_i, .rst_ni, .pwr_ok_i, .if_rst_i, .en_i, .static_lim_i,
    .hot_i, .back_i, .clamp_i,
    .stage_en_o, .otf_o, .bcf_o, .olf_o, .fault_n_o
  );

  typedef struct {
    logic [4:0] val;
    logic [4:0] msk;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected vector order: {stage_en, otf, bcf, olf, fault_n}
  task automatic expect_next(input logic [4:0] v, input logic [4:0] m, input string r);
    exp_t e;
    e.val = v; e.msk = m; e.req = r;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // monitor: items pushed at a negedge are judged after the following rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [4:0] obs;
        e = q.pop_front();
        obs = {stage_en_o, otf_o, bcf_o, olf_o, fault_n_o};
        checks++;
        if (((obs ^ e.val) & e.msk) != 5'b0) begin
          errors++;
          $display("FAIL %s at %0t: actual=%b expected=%b", e.req, $time, obs, e.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    expect_next(5'b00000, ALL, "R1 reset state");
    step();
    rst_ni = 1'b1; pwr_ok_i = 1'b1;
    expect_next(5'b00001, ALL, "R11 power ok, disabled");
    step();

    // static mode soft start and overload
    en_i = 1'b1; static_lim_i = 1'b1;
    expect_next(5'b10001, ALL, "R12 enable");
    step();
    clamp_i = 1'b1;
    expect_next(5'b10010, ALL, "R8 clamp sets olf");
    step();
    clamp_i = 1'b0;
    for (int k = 0; k < SS - 3; k++) begin
      expect_next(5'b10010, ALL, "R8 olf holds");
      step();
    end
    expect_next(5'b10010, ALL, "R9 olf before soft-start end");
    step();
    clamp_i = 1'b1;
    expect_next(5'b10001, ALL, "R9 end wins over clamp");
    step();
    clamp_i = 1'b0;
    expect_next(5'b10001, ALL, "R9 olf stays clear");
    step();

    // dynamic mode ignores clamp
    static_lim_i = 1'b0; clamp_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      expect_next(5'b10001, ALL, "R8 clamp ignored in dynamic mode");
      step();
    end
    clamp_i = 1'b0;

    // soft-start restart on enable edge
    en_i = 1'b0;
    expect_next(5'b00001, ALL, "R12 disable");
    step();
    en_i = 1'b1; static_lim_i = 1'b1; clamp_i = 1'b1;
    expect_next(5'b10010, ALL, "R10 clamp during restarted soft start");
    step();
    for (int k = 0; k < SS - 1; k++) begin
      expect_next(5'b10010, ALL, "R10 soft start running");
      step();
    end
    expect_next(5'b10001, ALL, "R10 soft start ends after SS edges");
    step();
    clamp_i = 1'b0; static_lim_i = 1'b0;
    expect_next(5'b10001, ALL, "R10 after soft start");
    step();

    // thermal shutdowns 1..3
    for (int i = 0; i < 3; i++) begin
      hot_i = 1'b1;
      expect_next(5'b01000, ALL, "R2 overtemp shuts off");
      step();
      hot_i = 1'b0;
      expect_next(5'b10001, ALL, "R2 overtemp clears");
      step();
    end
    // fourth shutdown latches
    hot_i = 1'b1;
    expect_next(5'b01000, ALL, "R3 fourth shutdown");
    step();
    hot_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      expect_next(5'b01000, ALL, "R3 latched off");
      step();
    end
    en_i = 1'b0;
    expect_next(5'b01000, ALL, "R3 latch holds with enable low");
    step();
    en_i = 1'b1;
    expect_next(5'b10001, ALL, "R4 enable edge clears latch");
    step();
    for (int i = 0; i < 3; i++) begin
      hot_i = 1'b1;
      expect_next(5'b01000, ALL, "R4 shutdown after clear");
      step();
      hot_i = 1'b0;
      if (i < 2) expect_next(5'b10001, ALL, "R4 count restarted");
      else       expect_next(5'b10001, ALL, "R4 third after clear not latched");
      step();
    end
    hot_i = 1'b1;
    expect_next(5'b01000, ALL, "R4 fourth after clear");
    step();
    hot_i = 1'b0;
    expect_next(5'b01000, ALL, "R4 relatched");
    step();
    pwr_ok_i = 1'b0;
    expect_next(5'b00000, ALL, "R1 power not ok");
    step();
    pwr_ok_i = 1'b1;
    expect_next(5'b10001, ALL, "R4 power cycle clears latch");
    step();

    // interface reset
    if_rst_i = 1'b1;
    expect_next(5'b10000, ALL, "R11 interface reset");
    step();
    if_rst_i = 1'b0;
    expect_next(5'b10001, ALL, "R11 interface reset released");
    step();

    // backward current retry
    back_i = 1'b1;
    for (int k = 0; k < RUN - 1; k++) begin
      expect_next(5'b10001, ALL, "R5 sensing window");
      step();
    end
    expect_next(5'b00101, ALL, "R5 backward trip");
    step();
    for (int k = 0; k < HOLD - 1; k++) begin
      expect_next(5'b00101, ALL, "R5 hold window");
      step();
    end
    expect_next(5'b10001, ALL, "R6 retry after hold");
    step();
    for (int k = 0; k < RUN - 1; k++) begin
      expect_next(5'b10001, ALL, "R6 retry window");
      step();
    end
    expect_next(5'b00101, ALL, "R6 second trip");
    step();
    back_i = 1'b0;
    for (int k = 0; k < HOLD - 1; k++) begin
      expect_next(5'b00101, ALL, "R6 second hold");
      step();
    end
    for (int k = 0; k < 4; k++) begin
      expect_next(5'b10001, ALL, "R6 resumed");
      step();
    end

    // short bursts never trip
    back_i = 1'b1;
    for (int k = 0; k < RUN - 1; k++) begin
      expect_next(5'b10001, ALL, "R7 first burst");
      step();
    end
    back_i = 1'b0;
    expect_next(5'b10001, ALL, "R7 gap");
    step();
    back_i = 1'b1;
    for (int k = 0; k < RUN - 1; k++) begin
      expect_next(5'b10001, ALL, "R7 second burst");
      step();
    end
    back_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      expect_next(5'b10001, ALL, "R7 no trip");
      step();
    end

    step();
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule